// File: doc/BRIEF.md
# Multi-Mode Microcontroller Host Port

This block is the host-facing front end of a display controller. A microcontroller reaches the controller over one of four bus styles: an 8080-style parallel bus, a 6800-style parallel bus, a four-wire SPI link or a three-wire SPI link. Three static mode pins select the style. All host pins are brought into the core clock domain through synchronizer chains. Every transfer the block accepts becomes one single-cycle write strobe that carries a byte and a command/data flag, or one single-cycle read request. A read request is answered from a status byte or from a display-memory byte, and that byte is placed on the parallel data bus with an output enable.

The chip select gates everything. While it is high, the strobes, the address line and the direction lines have no effect, and the data bus is released. In the serial styles, a high chip select also discards any partly received bits. The 6800 style has a second way to strobe: with the enable pin held high, the chip select itself acts as the enable.

Top module: `mcu_host_if`

## Requirements
- R1: Mode code 3'b000 selects four-wire SPI, 3'b100 three-wire SPI, 3'b011 the 8080 bus and 3'b111 the 6800 bus. Any other code produces no strobe, no read request and never enables the data bus.
- R2: While `cs_n_i` is high, toggling `rd_or_en_i`, `wr_or_rw_i` or `dc_sel_i` produces no write strobe and no read request, and `db_oe_o` stays low.
- R3: In 8080 mode, a rising edge of the active-low write strobe `wr_or_rw_i` while chip select is low yields one write strobe. The byte is `db_i` and `wr_dc_o` = `dc_sel_i`, where 1 means display data and 0 means command.
- R4: In 8080 mode, while chip select and the active-low read strobe `rd_or_en_i` are both low, `db_oe_o` is 1 and `db_o` is `rdata_i` when `dc_sel_i`=1 and `status_i` when it is 0. One `rd_req_o` pulse marks the start, with `rd_dc_o` = `dc_sel_i`.
- R5: In 6800 mode, a falling edge of the enable `rd_or_en_i` with chip select low and `wr_or_rw_i` low (write) yields one write strobe, with byte and flag taken as in R3.
- R6: In 6800 mode, while chip select is low, the enable is high and `wr_or_rw_i` is high (read), the bus is driven as in R4 and one `rd_req_o` pulse is issued.
- R7: In 6800 mode, with the enable held high, a rising edge of `cs_n_i` while `wr_or_rw_i` is low yields one write strobe that captures `db_i` and `dc_sel_i`.
- R8: In four-wire SPI, the serial clock is `db_i[0]` and the serial data is `db_i[1]`. Bits are taken MSB first on rising clock edges. The eighth bit completes a byte, and its flag is `dc_sel_i` at that edge.
- R9: In three-wire SPI, the first bit of each transfer is the command/data flag and the next eight bits are the byte, MSB first.
- R10: In both serial modes, raising chip select discards a partial transfer, so the next complete transfer is assembled from its own bits only.
- R11: Every accepted write gives exactly one `wr_stb_o` pulse of one cycle, and every read gives exactly one `rd_req_o` pulse of one cycle.
- R12: During reset, `wr_stb_o`, `rd_req_o` and `db_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Static bus-style selection |
| cs_n_i | input | 1 | Active-low chip select |
| dc_sel_i | input | 1 | Command (0) / data (1) select |
| rd_or_en_i | input | 1 | 8080 read strobe (active low) or 6800 enable |
| wr_or_rw_i | input | 1 | 8080 write strobe (active low) or 6800 read/write level |
| db_i | input | DW | Data bus input; serial clock on bit 0, serial data on bit 1 |
| db_o | output | DW | Data bus output value |
| db_oe_o | output | 1 | Data bus output enable |
| status_i | input | DW | Status byte returned when the select line is 0 |
| rdata_i | input | DW | Display-memory byte returned when the select line is 1 |
| rd_req_o | output | 1 | Single-cycle read request to the core |
| rd_dc_o | output | 1 | Target of the read request |
| wr_stb_o | output | 1 | Single-cycle write strobe to the core |
| wr_dc_o | output | 1 | Command/data flag of the written byte |
| wr_byte_o | output | DW | Written byte |

## Verification
Some properties are checked on every cycle. Write strobes and read requests never last more than one cycle, and a read request always comes with the bus enabled. The bus is enabled only in a parallel mode and never while chip select has been high for two cycles. A high chip select empties the serial bit counter and suppresses serial strobes. Other behaviour only the bench scenarios can show: which byte and flag a strobe carries, MSB-first order, the leading flag bit of three-wire transfers, the choice between status and memory on reads, the chip-select enable of the 6800 style, and that mode codes without a bus style stay silent.

// File: rtl/mhi_pkg.sv
package mhi_pkg;

   typedef enum logic [2:0] {
      BK_NONE = 3'd0,
      BK_SPI4 = 3'd1,
      BK_SPI3 = 3'd2,
      BK_I80  = 3'd3,
      BK_M68  = 3'd4
   } bus_kind_e;

   localparam logic [2:0] MODE_SPI4 = 3'b000;
   localparam logic [2:0] MODE_SPI3 = 3'b100;
   localparam logic [2:0] MODE_I80  = 3'b011;
   localparam logic [2:0] MODE_M68  = 3'b111;

   function automatic bus_kind_e decode_mode(input logic [2:0] m);
      case (m)
         MODE_SPI4: return BK_SPI4;
         MODE_SPI3: return BK_SPI3;
         MODE_I80:  return BK_I80;
         MODE_M68:  return BK_M68;
         default:   return BK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/mhi_sync.sv
module mhi_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mhi_par_rx.sv
module mhi_par_rx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          m68_i,
   input  logic          cs_n_s,
   input  logic          cs_n_q,
   input  logic          dc_s,
   input  logic          re_s,
   input  logic          re_q,
   input  logic          wr_s,
   input  logic          wr_q,
   input  logic [DW-1:0] data_s,
   output logic          wr_stb_o,
   output logic          wr_dc_o,
   output logic [DW-1:0] wr_byte_o,
   output logic          rd_req_o,
   output logic          rd_dc_o,
   output logic          rd_oe_o
);

   logic wr_hit;
   logic rd_lvl;

   always_comb begin
      if (m68_i) begin
         // enable falls with select low, or select rises with enable held high
         wr_hit = (!re_s && re_q && !cs_n_q && !wr_s)
                | ( cs_n_s && !cs_n_q && re_s && !wr_s);
         rd_lvl = !cs_n_s && re_s && wr_s;
      end else begin
         wr_hit = wr_s && !wr_q && !cs_n_q;
         rd_lvl = !cs_n_s && !re_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb_o  <= 1'b0;
         wr_dc_o   <= 1'b0;
         wr_byte_o <= '0;
         rd_req_o  <= 1'b0;
         rd_dc_o   <= 1'b0;
         rd_oe_o   <= 1'b0;
      end else begin
         wr_stb_o <= en_i && wr_hit;
         if (en_i && wr_hit) begin
            wr_byte_o <= data_s;
            wr_dc_o   <= dc_s;
         end
         rd_oe_o  <= en_i && rd_lvl;
         rd_req_o <= en_i && rd_lvl && !rd_oe_o;
         if (en_i && rd_lvl && !rd_oe_o) rd_dc_o <= dc_s;
      end
   end

   p_req_pulse_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);
   p_req_with_oe_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> rd_oe_o);

endmodule

// File: rtl/mhi_ser_rx.sv
module mhi_ser_rx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          three_wire_i,
   input  logic          cs_n_s,
   input  logic          sclk_s,
   input  logic          sclk_q,
   input  logic          sda_s,
   input  logic          dc_s,
   output logic          wr_stb_o,
   output logic          wr_dc_o,
   output logic [DW-1:0] wr_byte_o
);

   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] LAST4 = CW'(DW - 1);
   localparam logic [CW-1:0] LAST3 = CW'(DW);

   logic [DW-1:0] shreg;
   logic [CW-1:0] bit_cnt;
   logic          flag_bit;
   logic          sclk_rise;
   logic [CW-1:0] last_idx;

   assign sclk_rise = sclk_s && !sclk_q;
   assign last_idx  = three_wire_i ? LAST3 : LAST4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bit_cnt   <= '0;
         flag_bit  <= 1'b0;
         wr_stb_o  <= 1'b0;
         wr_dc_o   <= 1'b0;
         wr_byte_o <= '0;
      end else if (!en_i || cs_n_s) begin
         shreg    <= '0;
         bit_cnt  <= '0;
         flag_bit <= 1'b0;
         wr_stb_o <= 1'b0;
      end else begin
         wr_stb_o <= 1'b0;
         if (sclk_rise) begin
            if (three_wire_i && bit_cnt == '0) begin
               flag_bit <= sda_s;
               bit_cnt  <= bit_cnt + 1'b1;
            end else begin
               shreg <= {shreg[DW-2:0], sda_s};
               if (bit_cnt == last_idx) begin
                  wr_stb_o  <= 1'b1;
                  wr_byte_o <= {shreg[DW-2:0], sda_s};
                  wr_dc_o   <= three_wire_i ? flag_bit : dc_s;
                  bit_cnt   <= '0;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end

   p_cs_clears_cnt_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (bit_cnt == '0));
   p_cs_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !wr_stb_o);
   p_ser_pulse_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);

endmodule

// File: rtl/mcu_host_if.sv
module mcu_host_if #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_SERIAL  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    mode_i,
   input  logic          cs_n_i,
   input  logic          dc_sel_i,
   input  logic          rd_or_en_i,
   input  logic          wr_or_rw_i,
   input  logic [DW-1:0] db_i,
   output logic [DW-1:0] db_o,
   output logic          db_oe_o,
   input  logic [DW-1:0] status_i,
   input  logic [DW-1:0] rdata_i,
   output logic          rd_req_o,
   output logic          rd_dc_o,
   output logic          wr_stb_o,
   output logic          wr_dc_o,
   output logic [DW-1:0] wr_byte_o
);
   import mhi_pkg::*;

   localparam int SW = DW + 4;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("mcu_host_if: DW must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mcu_host_if: SYNC_STAGES must be at least 2");
      end
   endgenerate

   bus_kind_e kind;
   logic      par_en, ser_en;

   assign kind   = decode_mode(mode_i);
   assign par_en = (kind == BK_I80) || (kind == BK_M68);
   assign ser_en = (kind == BK_SPI4) || (kind == BK_SPI3);

   logic [SW-1:0] raw_vec, syn_vec;
   logic          cs_n_s, dc_s, re_s, wr_s;
   logic [DW-1:0] data_s;
   logic          cs_n_q, re_q, wr_q, sclk_q;

   assign raw_vec = {cs_n_i, dc_sel_i, rd_or_en_i, wr_or_rw_i, db_i};
   assign {cs_n_s, dc_s, re_s, wr_s, data_s} = syn_vec;

   mhi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_vec),
      .q_o   (syn_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_q <= 1'b1;
         re_q   <= 1'b1;
         wr_q   <= 1'b1;
         sclk_q <= 1'b1;
      end else begin
         cs_n_q <= cs_n_s;
         re_q   <= re_s;
         wr_q   <= wr_s;
         sclk_q <= data_s[0];
      end
   end

   logic          p_stb, p_dc, p_oe;
   logic [DW-1:0] p_byte;

   mhi_par_rx #(.DW(DW)) u_par (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (par_en),
      .m68_i     (kind == BK_M68),
      .cs_n_s    (cs_n_s),
      .cs_n_q    (cs_n_q),
      .dc_s      (dc_s),
      .re_s      (re_s),
      .re_q      (re_q),
      .wr_s      (wr_s),
      .wr_q      (wr_q),
      .data_s    (data_s),
      .wr_stb_o  (p_stb),
      .wr_dc_o   (p_dc),
      .wr_byte_o (p_byte),
      .rd_req_o  (rd_req_o),
      .rd_dc_o   (rd_dc_o),
      .rd_oe_o   (p_oe)
   );

   logic          s_stb, s_dc;
   logic [DW-1:0] s_byte;

   generate
      if (HAS_SERIAL) begin : g_serial
         mhi_ser_rx #(.DW(DW)) u_ser (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (ser_en),
            .three_wire_i (kind == BK_SPI3),
            .cs_n_s       (cs_n_s),
            .sclk_s       (data_s[0]),
            .sclk_q       (sclk_q),
            .sda_s        (data_s[1]),
            .dc_s         (dc_s),
            .wr_stb_o     (s_stb),
            .wr_dc_o      (s_dc),
            .wr_byte_o    (s_byte)
         );
      end else begin : g_no_serial
         assign s_stb  = 1'b0;
         assign s_dc   = 1'b0;
         assign s_byte = '0;
      end
   endgenerate

   assign wr_stb_o  = p_stb | s_stb;
   assign wr_dc_o   = p_stb ? p_dc   : s_dc;
   assign wr_byte_o = p_stb ? p_byte : s_byte;

   assign db_oe_o = p_oe;
   assign db_o    = p_oe ? (dc_s ? rdata_i : status_i) : '0;

   p_oe_released_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && $past(cs_n_s)) |-> !db_oe_o);
   p_oe_parallel_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      db_oe_o |-> par_en);
   p_wr_pulse_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);
   p_no_mode_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (kind == BK_NONE && $past(kind == BK_NONE)) |-> !(wr_stb_o || rd_req_o));

endmodule

// File: tb/mcu_host_if_tb.sv
module mcu_host_if_tb_top;

   localparam int DW = 8;
   localparam logic [7:0] STAT = 8'h5C;
   localparam logic [7:0] MEM  = 8'hA3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode = 3'b011;
   logic          cs_n = 1'b1, dc = 1'b1, re = 1'b1, wr = 1'b1;
   logic [DW-1:0] db = '1;
   logic [DW-1:0] db_o, wr_byte;
   logic          db_oe, rd_req, rd_dc, wr_stb, wr_dc;

   always #10 clk = ~clk;

   mcu_host_if #(.DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .cs_n_i(cs_n), .dc_sel_i(dc),
      .rd_or_en_i(re), .wr_or_rw_i(wr), .db_i(db), .db_o(db_o), .db_oe_o(db_oe),
      .status_i(STAT), .rdata_i(MEM), .rd_req_o(rd_req), .rd_dc_o(rd_dc),
      .wr_stb_o(wr_stb), .wr_dc_o(wr_dc), .wr_byte_o(wr_byte)
   );

   int n_chk = 0, n_bad = 0;
   int stb_cnt = 0, req_cnt = 0, stb_long = 0;
   logic [7:0] got_byte;
   logic got_dc, got_rdc, stb_prev;

   always @(posedge clk) begin
      if (wr_stb) begin
         stb_cnt <= stb_cnt + 1;
         got_byte <= wr_byte;
         got_dc <= wr_dc;
         if (stb_prev) stb_long <= stb_long + 1;
      end
      if (rd_req) begin
         req_cnt <= req_cnt + 1;
         got_rdc <= rd_dc;
      end
      stb_prev <= wr_stb;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr;
      @(negedge clk);
      stb_cnt = 0; req_cnt = 0; stb_long = 0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      cs_n = 1'b1; mode = m; wr = 1'b1;
      re = (m == 3'b111) ? 1'b0 : 1'b1;
      db = (m[1:0] == 2'b00) ? 8'hFC : 8'hFF;
      cyc(6);
   endtask

   task automatic i80_write(input logic a, input logic [7:0] b);
      cs_n = 0; dc = a; db = b; cyc(3);
      wr = 0; cyc(3); wr = 1; cyc(3);
      cs_n = 1; cyc(6);
   endtask

   task automatic m68_write(input logic a, input logic [7:0] b);
      cs_n = 0; wr = 0; dc = a; db = b; cyc(3);
      re = 1; cyc(3); re = 0; cyc(3);
      cs_n = 1; wr = 1; cyc(6);
   endtask

   task automatic m68_cs_write(input logic a, input logic [7:0] b);
      re = 1; wr = 0; dc = a; db = b; cyc(3);
      cs_n = 0; cyc(4); cs_n = 1; cyc(6);
      wr = 1; re = 0; cyc(4);
   endtask

   task automatic par_read(input bit m68, input logic a, input string tag);
      cs_n = 0; dc = a;
      if (m68) begin wr = 1; re = 1; end else re = 0;
      cyc(6);
      chk({tag, " oe"}, db_oe, 1'b1);
      chk({tag, " data"}, db_o, a ? MEM : STAT);
      if (m68) re = 0; else re = 1;
      cs_n = 1; cyc(6);
      chk({tag, " oe released"}, db_oe, 1'b0);
      chk({tag, " R11 one request"}, req_cnt, 1);
      chk({tag, " request target"}, got_rdc, a);
   endtask

   task automatic spi_bits(input logic [8:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         db[1] = w[i]; db[0] = 1'b0; cyc(3);
         db[0] = 1'b1; cyc(3);
      end
      db[0] = 1'b0; cyc(4);
   endtask

   task automatic spi_write(input bit three, input logic a, input logic [7:0] b);
      dc = a; cs_n = 0; cyc(3);
      if (three) spi_bits({a, b}, 9); else spi_bits({1'b0, b}, 8);
      cs_n = 1; cyc(6);
   endtask

   task automatic chk_write(input string tag, input logic a, input logic [7:0] b);
      chk({tag, " R11 one strobe"}, stb_cnt, 1);
      chk({tag, " R11 single cycle"}, stb_long, 0);
      chk({tag, " byte"}, got_byte, b);
      chk({tag, " flag"}, got_dc, a);
   endtask

   // op: 0 write, 1 read, 2 select-as-enable write, 3 serial write
   typedef struct packed {
      logic [2:0] md;
      logic [1:0] op;
      logic       a;
      logic [7:0] val;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{3'b011, 2'd0, 1'b1, 8'hA5}, '{3'b011, 2'd0, 1'b0, 8'h3C},
      '{3'b011, 2'd1, 1'b1, 8'h00}, '{3'b011, 2'd1, 1'b0, 8'h00},
      '{3'b111, 2'd0, 1'b1, 8'h0F}, '{3'b111, 2'd0, 1'b0, 8'hF0},
      '{3'b111, 2'd1, 1'b1, 8'h00}, '{3'b111, 2'd1, 1'b0, 8'h00},
      '{3'b111, 2'd2, 1'b1, 8'h81}, '{3'b111, 2'd2, 1'b0, 8'h7E},
      '{3'b000, 2'd3, 1'b1, 8'hC3}, '{3'b000, 2'd3, 1'b0, 8'h5A},
      '{3'b100, 2'd3, 1'b1, 8'h96}, '{3'b100, 2'd3, 1'b0, 8'h01}
   };

   bit done = 0;

   initial begin
      cyc(3);
      chk("R12 reset strobe", wr_stb, 0);
      chk("R12 reset request", rd_req, 0);
      chk("R12 reset oe", db_oe, 0);
      rst_n = 1'b1;
      cyc(4);

      foreach (VECS[k]) begin
         vec_t v;
         v = VECS[k];
         set_mode(v.md);
         clr();
         case (v.op)
            2'd0: begin
               if (v.md == 3'b011) begin i80_write(v.a, v.val); chk_write("R3", v.a, v.val); end
               else begin m68_write(v.a, v.val); chk_write("R5", v.a, v.val); end
            end
            2'd1: begin
               if (v.md == 3'b011) par_read(1'b0, v.a, "R4");
               else par_read(1'b1, v.a, "R6");
            end
            2'd2: begin m68_cs_write(v.a, v.val); chk_write("R7", v.a, v.val); end
            default: begin
               if (v.md == 3'b000) begin spi_write(1'b0, v.a, v.val); chk_write("R8", v.a, v.val); end
               else begin spi_write(1'b1, v.a, v.val); chk_write("R9", v.a, v.val); end
            end
         endcase
      end

      // R2: 8080 strobes with chip select high
      set_mode(3'b011); clr();
      dc = 1; db = 8'h11; wr = 0; cyc(3); wr = 1; cyc(3);
      re = 0; cyc(6);
      chk("R2 8080 oe with cs high", db_oe, 0);
      re = 1; dc = 0; cyc(6);
      chk("R2 8080 no strobe", stb_cnt, 0);
      chk("R2 8080 no request", req_cnt, 0);

      // R2: 6800 enable and read/write with chip select high
      set_mode(3'b111); clr();
      wr = 0; re = 1; cyc(3); re = 0; cyc(3);
      wr = 1; re = 1; cyc(6);
      chk("R2 6800 oe with cs high", db_oe, 0);
      re = 0; cyc(6);
      chk("R2 6800 no strobe", stb_cnt, 0);
      chk("R2 6800 no request", req_cnt, 0);

      // R1: unused mode code stays silent
      set_mode(3'b010); clr();
      i80_write(1'b1, 8'h42);
      cs_n = 0; re = 0; cyc(6);
      chk("R1 unused mode oe", db_oe, 0);
      re = 1; cs_n = 1; cyc(4);
      spi_write(1'b0, 1'b1, 8'h42);
      chk("R1 unused mode no strobe", stb_cnt, 0);
      chk("R1 unused mode no request", req_cnt, 0);

      // R10: partial serial transfer is dropped by chip select
      set_mode(3'b000); clr();
      dc = 1; cs_n = 0; cyc(3);
      spi_bits(9'h1FF, 3);
      cs_n = 1; cyc(6);
      spi_write(1'b0, 1'b0, 8'h24);
      chk("R10 4-wire one strobe", stb_cnt, 1);
      chk("R10 4-wire byte", got_byte, 8'h24);
      set_mode(3'b100); clr();
      cs_n = 0; cyc(3);
      spi_bits(9'h1FF, 5);
      cs_n = 1; cyc(6);
      spi_write(1'b1, 1'b0, 8'h6B);
      chk("R10 3-wire one strobe", stb_cnt, 1);
      chk("R10 3-wire byte", got_byte, 8'h6B);
      chk("R10 3-wire flag", got_dc, 1'b0);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule